// File: doc/BRIEF.md
# Table-Driven Serial Flash Sequence Engine

This block runs serial-flash transactions that software describes in a small instruction table, rather than in fixed state-machine logic. Software loads the table through a word-wide register port. Each sequence is a short program made of instructions: send an opcode byte, send the address, idle for some clocks, receive bytes, or transmit bytes. The engine then plays one sequence on a single-lane SPI link in mode 0.

A host starts a transaction by writing a command word. The word names a sequence slot and gives a byte count for transfers that take their length from the command. The engine keeps chip select asserted for the whole sequence. It puts received bytes into a receive FIFO and pulls transmitted bytes from a transmit FIFO. The table can be frozen against stray writes. Unfreezing or freezing it takes a key write followed by a lock-control write.

Top module: `seqeng_top`

## Requirements
- R1: Sequence N uses table words 4N to 4N+3. Each word holds two 16-bit instructions, and the one in bits [15:0] runs before the one in bits [31:16]. Each instruction has opcode [15:10], lane width [9:8] and operand [7:0]. Opcode 0 is stop, 1 sends a byte, 2 sends the address, 3 is dummy cycles, 4 is read and 5 is write.
- R2: A byte-send instruction shifts its operand out on `mosi`, MSB first. `mosi` changes only while `sck` is low, and each bit is held across the rising edge of `sck`. `sck` idles low whenever `cs_n` is high.
- R3: An address instruction with operand 32 sends all 32 bits of the flash address register (offset 1). Any other operand sends only bits [23:0]. Both are sent MSB first.
- R4: A dummy instruction produces as many `sck` cycles as its operand, with `mosi` low. An operand of 0 is skipped.
- R5: A read instruction shifts bytes in from `miso` MSB first, sampling at each rising edge of `sck`, and pushes each byte into the receive FIFO. A write instruction sends bytes taken from the transmit FIFO, and sends 0x00 for any byte the FIFO cannot supply.
- R6: A read or write instruction with a nonzero operand moves that many bytes. With operand 0 it moves the size field of the command word, and a size of 0 skips the instruction.
- R7: `cs_n` is low from the first cycle of a sequence until it ends. A sequence ends at a stop instruction (an all-zero word stops it) or after its eighth instruction.
- R8: The table comes out of reset locked, and table writes (offsets 64 and up, word index in the low bits) are ignored while it is locked. Writing the key 0x5AF05AF0 to offset 2, then writing offset 3 as the very next register write, unlocks the table when bit 0 is set and locks it when bit 1 is set. A lock-control write that does not directly follow the matching key is ignored.
- R9: A write to offset 0 starts a sequence. Bits [27:24] of that write select the sequence and bits [15:0] give the size. `busy` is high from the next cycle until the sequence ends.
- R10: A command written while `busy` is high is ignored and sets `err`, which stays set until reset.
- R11: After reset, `cs_n` is high, `sck` is low, `busy` and `err` are low, the receive FIFO is empty and `locked` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register offset; top bit selects the table |
| reg_wdata | input | 32 | Register write data |
| tx_push | input | 1 | Push a byte into the transmit FIFO |
| tx_data | input | 8 | Transmit byte |
| tx_full | output | 1 | Transmit FIFO full |
| rx_pop | input | 1 | Pop the receive FIFO |
| rx_data | output | 8 | Head of the receive FIFO |
| rx_empty | output | 1 | Receive FIFO empty |
| busy | output | 1 | Sequence running |
| err | output | 1 | Sticky flag for a command written while busy |
| locked | output | 1 | Table write protection active |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |

## Verification
A wrong instruction pointer or a mis-decoded field shows up at the pins within one instruction. The count of `sck` edges or the bytes on `mosi` differ from the sequence as programmed, and chip select rises early or late. A wrong bit or byte counter shifts every later byte. The first four `mosi` bytes and the total edge count therefore pin down most faults for each sequence. Lock or key faults appear only when the affected sequence is replayed, so each lock step is followed by a run that exposes the table contents.

// File: rtl/seqeng_pkg.sv
`timescale 1ns/1ps
package seqeng_pkg;
   typedef enum logic [5:0] {
      OP_STOP  = 6'd0,
      OP_CMD   = 6'd1,
      OP_ADDR  = 6'd2,
      OP_DUMMY = 6'd3,
      OP_READ  = 6'd4,
      OP_WRITE = 6'd5
   } op_e;

   typedef struct packed {
      op_e        op;
      logic [1:0] lanes;
      logic [7:0] opr;
   } instr_t;

   localparam int OFF_CMD   = 0;
   localparam int OFF_FADDR = 1;
   localparam int OFF_KEY   = 2;
   localparam int OFF_LOCK  = 3;
endpackage

// File: rtl/seqeng_fifo.sv
`timescale 1ns/1ps
module seqeng_fifo #(
   parameter int DW    = 8,
   parameter int DEPTH = 16,
   localparam int PW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] din,
   input  logic          pop,
   output logic [DW-1:0] dout,
   output logic          empty,
   output logic          full
);
   logic [DW-1:0] mem [DEPTH];
   logic [PW:0]   wp, rp;

   assign empty = (wp == rp);
   assign full  = (wp[PW] != rp[PW]) && (wp[PW-1:0] == rp[PW-1:0]);
   assign dout  = mem[rp[PW-1:0]];

   always_ff @(posedge clk) begin
      if (push && !full) mem[wp[PW-1:0]] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
      end else begin
         if (push && !full) wp <= wp + 1'b1;
         if (pop && !empty) rp <= rp + 1'b1;
      end
   end
endmodule

// File: rtl/seqeng_table.sv
`timescale 1ns/1ps
module seqeng_table #(
   parameter int          NWORDS = 64,
   parameter logic [31:0] KEY    = 32'h5AF0_5AF0,
   localparam int         IW     = $clog2(NWORDS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          any_we,
   input  logic          key_we,
   input  logic          lk_we,
   input  logic          tw_we,
   input  logic [31:0]   wdata,
   input  logic [IW-1:0] tw_idx,
   input  logic [IW-1:0] rd_idx,
   output logic [31:0]   rd_data,
   output logic          locked
);
   logic [31:0] words [NWORDS];
   logic        armed;

   assign rd_data = words[rd_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked <= 1'b1;
         armed  <= 1'b0;
         for (int i = 0; i < NWORDS; i++) words[i] <= '0;
      end else begin
         if (key_we)      armed <= (wdata == KEY);
         else if (any_we) armed <= 1'b0;
         if (lk_we && armed) begin
            if (wdata[1])      locked <= 1'b1;
            else if (wdata[0]) locked <= 1'b0;
         end
         if (tw_we && !locked) words[tw_idx] <= wdata;
      end
   end
endmodule

// File: rtl/seqeng_exec.sv
`timescale 1ns/1ps
module seqeng_exec
   import seqeng_pkg::*;
#(
   parameter int  SEQ_W     = 4,
   parameter int  SIZE_W    = 16,
   parameter bit  ADDR32_EN = 1'b1,
   localparam int IW        = SEQ_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [SEQ_W-1:0]  start_seq,
   input  logic [SIZE_W-1:0] start_size,
   input  logic [31:0]       faddr,
   output logic [IW-1:0]     rd_idx,
   input  logic [31:0]       rd_data,
   input  logic              tx_empty,
   input  logic [7:0]        tx_data,
   output logic              tx_pop,
   output logic              rx_push,
   output logic [7:0]        rx_byte,
   output logic              busy,
   output logic              sck,
   output logic              cs_n,
   output logic              mosi,
   input  logic              miso
);
   typedef enum logic [1:0] {S_IDLE, S_DEC, S_LO, S_HI} st_e;

   st_e               st;
   logic [SEQ_W-1:0]  seq_q;
   logic [2:0]        slot_q;
   logic [SIZE_W-1:0] size_q, units_q, xfer_cnt;
   logic [7:0]        bits_q, rx_q, txb;
   logic [31:0]       sh_q;
   op_e               kind_q;
   logic              cs_q, sck_q, wide, last_bit, last_unit;
   instr_t            ins;

   assign ins      = slot_q[0] ? instr_t'(rd_data[31:16]) : instr_t'(rd_data[15:0]);
   assign rd_idx   = {seq_q, slot_q[2:1]};
   assign xfer_cnt = (ins.opr != 8'd0) ? SIZE_W'(ins.opr) : size_q;

   generate
      if (ADDR32_EN) begin : g_addr32
         assign wide = (ins.opr == 8'd32);
      end else begin : g_addr24
         assign wide = 1'b0;
      end
   endgenerate

   assign last_bit  = (bits_q == 8'd1);
   assign last_unit = (units_q == SIZE_W'(1));
   assign txb       = tx_empty ? 8'h00 : tx_data;
   assign tx_pop    = !tx_empty &&
                      ((st == S_DEC && ins.op == OP_WRITE && xfer_cnt != '0) ||
                       (st == S_HI && last_bit && !last_unit && kind_q == OP_WRITE));
   assign rx_push   = (st == S_HI) && last_bit && (kind_q == OP_READ);
   assign rx_byte   = rx_q;
   assign busy      = (st != S_IDLE);
   assign sck       = sck_q;
   assign cs_n      = cs_q;
   assign mosi      = sh_q[31];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         seq_q   <= '0;
         slot_q  <= '0;
         size_q  <= '0;
         units_q <= '0;
         bits_q  <= '0;
         rx_q    <= '0;
         sh_q    <= '0;
         kind_q  <= OP_STOP;
         cs_q    <= 1'b1;
         sck_q   <= 1'b0;
      end else begin
         case (st)
            S_IDLE: if (start) begin
               seq_q  <= start_seq;
               size_q <= start_size;
               slot_q <= '0;
               cs_q   <= 1'b0;
               st     <= S_DEC;
            end
            S_DEC: begin
               units_q <= SIZE_W'(1);
               kind_q  <= ins.op;
               case (ins.op)
                  OP_CMD: begin
                     sh_q   <= {ins.opr, 24'h0};
                     bits_q <= 8'd8;
                     st     <= S_LO;
                  end
                  OP_ADDR: begin
                     sh_q   <= wide ? faddr : {faddr[23:0], 8'h0};
                     bits_q <= wide ? 8'd32 : 8'd24;
                     st     <= S_LO;
                  end
                  OP_DUMMY: begin
                     if (ins.opr == 8'd0) begin
                        if (slot_q == 3'd7) begin cs_q <= 1'b1; st <= S_IDLE; end
                        else slot_q <= slot_q + 3'd1;
                     end else begin
                        sh_q   <= '0;
                        bits_q <= ins.opr;
                        st     <= S_LO;
                     end
                  end
                  OP_READ, OP_WRITE: begin
                     if (xfer_cnt == '0) begin
                        if (slot_q == 3'd7) begin cs_q <= 1'b1; st <= S_IDLE; end
                        else slot_q <= slot_q + 3'd1;
                     end else begin
                        units_q <= xfer_cnt;
                        bits_q  <= 8'd8;
                        sh_q    <= {(ins.op == OP_WRITE) ? txb : 8'h00, 24'h0};
                        st      <= S_LO;
                     end
                  end
                  default: begin
                     cs_q <= 1'b1;
                     st   <= S_IDLE;
                  end
               endcase
            end
            S_LO: begin
               sck_q <= 1'b1;
               rx_q  <= {rx_q[6:0], miso};
               st    <= S_HI;
            end
            S_HI: begin
               sck_q  <= 1'b0;
               sh_q   <= sh_q << 1;
               bits_q <= bits_q - 8'd1;
               st     <= S_LO;
               if (last_bit) begin
                  if (last_unit) begin
                     if (slot_q == 3'd7) begin
                        cs_q <= 1'b1;
                        st   <= S_IDLE;
                     end else begin
                        slot_q <= slot_q + 3'd1;
                        st     <= S_DEC;
                     end
                  end else begin
                     units_q <= units_q - SIZE_W'(1);
                     bits_q  <= 8'd8;
                     if (kind_q == OP_WRITE) sh_q <= {txb, 24'h0};
                  end
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/seqeng_top.sv
`timescale 1ns/1ps
module seqeng_top
   import seqeng_pkg::*;
#(
   parameter int          NSEQ       = 16,
   parameter int          SIZE_W     = 16,
   parameter int          FIFO_DEPTH = 16,
   parameter bit          ADDR32_EN  = 1'b1,
   parameter logic [31:0] LOCK_KEY   = 32'h5AF0_5AF0,
   localparam int         RA_W       = $clog2(NSEQ * 4) + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_we,
   input  logic [RA_W-1:0] reg_addr,
   input  logic [31:0]     reg_wdata,
   input  logic            tx_push,
   input  logic [7:0]      tx_data,
   output logic            tx_full,
   input  logic            rx_pop,
   output logic [7:0]      rx_data,
   output logic            rx_empty,
   output logic            busy,
   output logic            err,
   output logic            locked,
   output logic            sck,
   output logic            cs_n,
   output logic            mosi,
   input  logic            miso
);
   localparam int SEQ_W  = $clog2(NSEQ);
   localparam int NWORDS = NSEQ * 4;
   localparam int TW_W   = $clog2(NWORDS);

   generate
      if (NSEQ < 2 || NSEQ > 16 || (NSEQ & (NSEQ - 1)) != 0) begin : g_bad_nseq
         initial $fatal(1, "NSEQ must be a power of two from 2 to 16");
      end
      if (SIZE_W < 8 || SIZE_W > 24) begin : g_bad_size
         initial $fatal(1, "SIZE_W must lie in 8..24");
      end
      if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_fifo
         initial $fatal(1, "FIFO_DEPTH must be a power of two");
      end
   endgenerate

   logic              tsel, cmd_we, fa_we, key_we, lk_we, tw_we, start;
   logic [RA_W-2:0]   off;
   logic [31:0]       faddr_q, rd_data;
   logic [TW_W-1:0]   rd_idx;
   logic              tx_empty, tx_pop, rx_push, rx_full;
   logic [7:0]        tx_head, rx_byte;

   assign tsel   = reg_addr[RA_W-1];
   assign off    = reg_addr[RA_W-2:0];
   assign cmd_we = reg_we && !tsel && (off == (RA_W-1)'(OFF_CMD));
   assign fa_we  = reg_we && !tsel && (off == (RA_W-1)'(OFF_FADDR));
   assign key_we = reg_we && !tsel && (off == (RA_W-1)'(OFF_KEY));
   assign lk_we  = reg_we && !tsel && (off == (RA_W-1)'(OFF_LOCK));
   assign tw_we  = reg_we && tsel;
   assign start  = cmd_we && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         faddr_q <= '0;
         err     <= 1'b0;
      end else begin
         if (fa_we) faddr_q <= reg_wdata;
         if (cmd_we && busy) err <= 1'b1;
      end
   end

   seqeng_table #(.NWORDS(NWORDS), .KEY(LOCK_KEY)) u_table (
      .clk(clk), .rst_n(rst_n), .any_we(reg_we), .key_we(key_we),
      .lk_we(lk_we), .tw_we(tw_we), .wdata(reg_wdata),
      .tw_idx(reg_addr[TW_W-1:0]), .rd_idx(rd_idx), .rd_data(rd_data),
      .locked(locked)
   );

   seqeng_exec #(.SEQ_W(SEQ_W), .SIZE_W(SIZE_W), .ADDR32_EN(ADDR32_EN)) u_exec (
      .clk(clk), .rst_n(rst_n), .start(start),
      .start_seq(reg_wdata[24 +: SEQ_W]), .start_size(reg_wdata[SIZE_W-1:0]),
      .faddr(faddr_q), .rd_idx(rd_idx), .rd_data(rd_data),
      .tx_empty(tx_empty), .tx_data(tx_head), .tx_pop(tx_pop),
      .rx_push(rx_push), .rx_byte(rx_byte), .busy(busy),
      .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso)
   );

   seqeng_fifo #(.DW(8), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .push(tx_push), .din(tx_data),
      .pop(tx_pop), .dout(tx_head), .empty(tx_empty), .full(tx_full)
   );

   seqeng_fifo #(.DW(8), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_byte),
      .pop(rx_pop), .dout(rx_data), .empty(rx_empty), .full(rx_full)
   );
endmodule

// File: rtl/seqeng_chk.sv
`timescale 1ns/1ps
module seqeng_chk (
   input logic clk,
   input logic rst_n,
   input logic cmd_we,
   input logic busy,
   input logic err,
   input logic cs_n,
   input logic sck,
   input logic mosi
);
   AST_BUSY_TRACKS_SELECT: assert property (@(posedge clk) disable iff (!rst_n) busy == !cs_n); // R7
   AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sck); // R2
   AST_MOSI_HELD_HIGH_PHASE: assert property (@(posedge clk) disable iff (!rst_n) sck |-> $stable(mosi)); // R2
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) err |=> err); // R10
   AST_ERR_ON_BUSY_CMD: assert property (@(posedge clk) disable iff (!rst_n) (cmd_we && busy) |=> err); // R10
   AST_CMD_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (cmd_we && !busy) |=> busy); // R9
endmodule

bind seqeng_top seqeng_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .busy(busy),
   .err(err), .cs_n(cs_n), .sck(sck), .mosi(mosi)
);

// File: tb/seqeng_top_tb_top.sv
`timescale 1ns/1ps
module seqeng_top_tb_top;
   localparam logic [31:0] KEY = 32'h5AF0_5AF0;

   typedef struct packed {
      logic [3:0]  seq;
      logic [15:0] size;
      logic [31:0] addr;
      logic [15:0] edges;
      logic [31:0] head;
      logic [7:0]  rxn;
      logic [7:0]  k0;
   } vec_t;

   localparam vec_t VECS [7] = '{
      '{4'd0, 16'd0, 32'h0000_0000, 16'd8,  32'h0600_0000, 8'd0, 8'd0},
      '{4'd1, 16'd2, 32'h0012_3456, 16'd56, 32'h0B12_3456, 8'd2, 8'd5},
      '{4'd3, 16'd5, 32'h0000_0000, 16'd32, 32'h9F00_0000, 8'd3, 8'd1},
      '{4'd4, 16'd9, 32'hA1B2_C3D4, 16'd48, 32'h0CA1_B2C3, 8'd1, 8'd5},
      '{4'd5, 16'd0, 32'h0000_0000, 16'd64, 32'h1122_3344, 8'd0, 8'd0},
      '{4'd1, 16'd0, 32'h00AB_CDEF, 16'd40, 32'h0BAB_CDEF, 8'd0, 8'd0},
      '{4'd6, 16'd0, 32'h0000_0000, 16'd8,  32'h5A00_0000, 8'd0, 8'd0}
   };

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       reg_we = 1'b0, tx_push = 1'b0, rx_pop = 1'b0;
   logic [6:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [7:0] tx_data = '0;
   logic       tx_full, rx_empty, busy, err, locked, sck, cs_n, mosi, miso;
   logic [7:0] rx_data;
   int         n_cmp = 0, n_bad = 0, edges = 0;
   logic [7:0] cap [16];

   always #4 clk = ~clk;

   seqeng_top dut_i (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .tx_push(tx_push), .tx_data(tx_data),
      .tx_full(tx_full), .rx_pop(rx_pop), .rx_data(rx_data),
      .rx_empty(rx_empty), .busy(busy), .err(err), .locked(locked),
      .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso)
   );

   function automatic logic pat_bit(input int e);
      logic [7:0] b;
      b = 8'hC0 + 8'(e / 8);
      return b[3'(7 - e % 8)];
   endfunction

   assign miso = cs_n ? 1'b0 : pat_bit(edges);

   always @(negedge cs_n or posedge sck) begin
      if (!sck) begin
         edges = 0;
         for (int i = 0; i < 16; i++) cap[i] = 8'h00;
      end else if (!cs_n) begin
         if (edges < 128) cap[edges / 8][3'(7 - edges % 8)] = mosi;
         edges = edges + 1;
      end
   end

   function automatic logic [15:0] ins(input int op, input logic [7:0] opr);
      return {6'(op), 2'b00, opr};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 7'(a); reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
   endtask

   task automatic run(input int seq, input int size);
      wr(0, (32'(seq) << 24) | 32'(size));
      wait_idle();
   endtask

   task automatic push_tx(input logic [7:0] b);
      @(negedge clk); tx_push = 1'b1; tx_data = b;
      @(negedge clk); tx_push = 1'b0;
   endtask

   task automatic drain(input string req, input int n_exp, input int k0);
      int n = 0;
      while (!rx_empty && n < 32) begin
         @(negedge clk);
         chk(req, {24'h0, rx_data}, {24'h0, 8'hC0 + 8'(k0 + n)});
         rx_pop = 1'b1;
         @(negedge clk);
         rx_pop = 1'b0;
         n++;
      end
      chk(req, 32'(n), 32'(n_exp));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11 cs_n", {31'h0, cs_n}, 32'h1);
      chk("R11 sck", {31'h0, sck}, 32'h0);
      chk("R11 busy", {31'h0, busy}, 32'h0);
      chk("R11 err", {31'h0, err}, 32'h0);
      chk("R11 rx_empty", {31'h0, rx_empty}, 32'h1);
      chk("R11 locked", {31'h0, locked}, 32'h1);

      // R8 lock-control without key, and with wrong key
      wr(3, 32'h1);
      chk("R8 no key", {31'h0, locked}, 32'h1);
      wr(2, 32'h1234_5678); wr(3, 32'h1);
      chk("R8 bad key", {31'h0, locked}, 32'h1);
      wr(2, KEY); wr(1, 32'h0); wr(3, 32'h1);
      chk("R8 key not adjacent", {31'h0, locked}, 32'h1);
      wr(64, {16'h0, ins(1, 8'h06)});
      run(0, 0);
      chk("R8 locked write ignored", 32'(edges), 32'd0);

      wr(2, KEY); wr(3, 32'h1);
      chk("R8 unlock", {31'h0, locked}, 32'h0);

      // R1 table load
      wr(64 + 0,  {16'h0, ins(1, 8'h06)});
      wr(64 + 4,  {ins(2, 8'd24), ins(1, 8'h0B)});
      wr(64 + 5,  {ins(4, 8'd0), ins(3, 8'd8)});
      wr(64 + 8,  {ins(2, 8'd24), ins(1, 8'h02)});
      wr(64 + 9,  {16'h0, ins(5, 8'd0)});
      wr(64 + 12, {ins(4, 8'd3), ins(1, 8'h9F)});
      wr(64 + 16, {ins(2, 8'd32), ins(1, 8'h0C)});
      wr(64 + 17, {16'h0, ins(4, 8'd1)});
      wr(64 + 20, {ins(1, 8'h22), ins(1, 8'h11)});
      wr(64 + 21, {ins(1, 8'h44), ins(1, 8'h33)});
      wr(64 + 22, {ins(1, 8'h66), ins(1, 8'h55)});
      wr(64 + 23, {ins(1, 8'h88), ins(1, 8'h77)});
      wr(64 + 24, {ins(1, 8'h5A), ins(3, 8'd0)});

      for (int v = 0; v < 7; v++) begin
         wr(1, VECS[v].addr);
         wr(0, {4'h0, VECS[v].seq, 8'h0, VECS[v].size});
         chk("R9 busy after command", {31'h0, busy}, 32'h1);
         wait_idle();
         chk("R7 R4 R6 edge count", 32'(edges), 32'(VECS[v].edges));
         chk("R1 R2 R3 head bytes", {cap[0], cap[1], cap[2], cap[3]}, VECS[v].head);
         chk("R7 cs_n released", {31'h0, cs_n}, 32'h1);
         drain("R5 R6 read data", int'(VECS[v].rxn), int'(VECS[v].k0));
      end

      // R4 dummy cycles drive mosi low
      wr(1, 32'hFFFF_FFFF);
      run(1, 1);
      chk("R4 dummy byte", {24'h0, cap[4]}, 32'h0);
      chk("R4 edges", 32'(edges), 32'd48);
      drain("R5 read one", 1, 5);

      // R5 write from tx FIFO, zero on underflow
      push_tx(8'h3C); push_tx(8'h7E);
      wr(1, 32'h0001_0203);
      run(2, 3);
      chk("R5 write b0", {24'h0, cap[4]}, 32'h3C);
      chk("R5 write b1", {24'h0, cap[5]}, 32'h7E);
      chk("R5 underflow", {24'h0, cap[6]}, 32'h00);
      chk("R5 write edges", 32'(edges), 32'd56);

      // R10 command while busy
      wr(1, 32'h0);
      wr(0, {8'h01, 8'h0, 16'd2});
      wr(0, {8'h00, 8'h0, 16'd0});
      chk("R10 err set", {31'h0, err}, 32'h1);
      wait_idle();
      chk("R10 ignored cmd", 32'(edges), 32'd56);
      drain("R10 rx", 2, 5);
      repeat (3) @(negedge clk);
      chk("R10 sticky", {31'h0, err}, 32'h1);

      // R8 relock
      wr(2, KEY); wr(3, 32'h2);
      chk("R8 relock", {31'h0, locked}, 32'h1);
      wr(64, {16'h0, ins(1, 8'h99)});
      run(0, 0);
      chk("R8 relocked write ignored", {24'h0, cap[0]}, 32'h06);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule